// File: doc/BRIEF.md
# Error Capture and Interrupt Status Register

This block records faults reported by a multi-channel memory access engine and presents them to software. A fault event comes with a channel number, a flag that says whether that number is known, a bus identifier and an error kind code. On each event the block does four things. It sets the status bit that belongs to the error kind. It may capture the event's details into a description field that carries a valid flag. If the channel is known, it clears that channel's bit in the channel-active register. It raises a registered interrupt when any pending status bit is enabled.

A configuration bit selects how the description is captured. In hold-first mode, the details of the first fault stay frozen until software clears the valid flag. In latest-wins mode, every fault replaces the stored details. In both modes the status bits keep accumulating. Software reaches the configuration, error, enable and channel-active registers through a plain register port. Writes take effect at the clock edge, and reads are combinational.

Top module: `err_log_reg`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A fault of kind k sets error-register bit k (k < NKIND), and set bits accumulate across faults of different kinds.
- R3: Writing the error register (address 1) clears each status bit whose data bit is 1, and data bits at 0 leave status unchanged. A fault in the same cycle as the clear keeps its bit set.
- R4: With config bit 0 set (hold-first), the first fault's description stays unchanged while the valid flag (error-register bit 31) is 1. Later faults only set status bits.
- R5: Every fault written into the description sets bit 31, and writing 1 to bit 31 clears it. In hold-first mode, a fault arriving in the same cycle as that clear is captured and leaves bit 31 set.
- R6: With config bit 0 clear (latest-wins), each fault overwrites the description. The description fields are channel in bits [15:8], bus in [19:16], kind in [23:20] and channel-known in bit 24.
- R7: A fault whose channel-known flag is 1 clears bit `chan` of the channel-active register (address 3). A fault with the flag at 0 leaves that register unchanged.
- R8: `irq` equals the OR of (status AND enable) as it stood one cycle earlier, where the enable register is at address 2.
- R9: Config (address 0, bit 0), enable and channel-active registers read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | 1 | Fault event strobe, one cycle per fault |
| err_chan | input | CHW | Faulting channel number |
| err_chan_known | input | 1 | Channel number is meaningful |
| err_bus | input | BUSW | Bus on which the fault occurred |
| err_kind | input | KW | Error kind code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| chan_active | output | NCHAN | Channel-active register contents |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, four error kinds, a two-bit bus field and a two-bit kind code. With these values every status bit and every description field can be driven to a distinct nonzero value, so a wrong field position or a stale capture changes the read value. Eight channels are enough to show a known fault clearing exactly one channel bit while an unknown one clears none. They also make room for the two same-cycle races: a status clear against a new fault, and a valid-flag clear against a locked capture.

// File: rtl/err_log_reg.sv
module err_log_reg #(
  parameter int NCHAN = 8,
  parameter int NKIND = 4,
  parameter int BUSW  = 2,
  parameter int KW    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     err_in,
  input  logic [$clog2(NCHAN)-1:0] err_chan,
  input  logic                     err_chan_known,
  input  logic [BUSW-1:0]          err_bus,
  input  logic [KW-1:0]            err_kind,
  input  logic                     reg_we,
  input  logic [1:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [NCHAN-1:0]         chan_active,
  output logic                     irq
);
  localparam int CHW = $clog2(NCHAN);
  localparam logic [1:0] A_CFG = 2'd0, A_ESR = 2'd1, A_IER = 2'd2, A_ACT = 2'd3;

  logic             lock_q, vld_q, known_q, irq_q;
  logic [NKIND-1:0] stat_q, ier_q, set_vec, clr_vec;
  logic [NCHAN-1:0] act_q;
  logic [CHW-1:0]   chan_q;
  logic [BUSW-1:0]  bus_q;
  logic [KW-1:0]    kind_q;

  wire wr_esr  = reg_we && reg_addr == A_ESR;
  wire vclr    = wr_esr && reg_wdata[31];
  wire capture = err_in && (!lock_q || !vld_q || vclr);

  always_comb begin
    for (int i = 0; i < NKIND; i++)
      set_vec[i] = err_in && (err_kind == KW'(i));
    clr_vec = wr_esr ? reg_wdata[NKIND-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      vld_q   <= 1'b0;
      known_q <= 1'b0;
      stat_q  <= '0;
      ier_q   <= '0;
      act_q   <= '0;
      chan_q  <= '0;
      bus_q   <= '0;
      kind_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CFG) lock_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_IER) ier_q  <= reg_wdata[NKIND-1:0];
      if (reg_we && reg_addr == A_ACT) act_q  <= reg_wdata[NCHAN-1:0];
      if (err_in && err_chan_known)    act_q[err_chan] <= 1'b0;
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      if (capture) begin
        vld_q   <= 1'b1;
        chan_q  <= err_chan;
        known_q <= err_chan_known;
        bus_q   <= err_bus;
        kind_q  <= err_kind;
      end else if (vclr) begin
        vld_q <= 1'b0;
      end
      irq_q <= |(stat_q & ier_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG: reg_rdata[0] = lock_q;
      A_ESR: begin
        reg_rdata[NKIND-1:0]  = stat_q;
        reg_rdata[8 +: CHW]   = chan_q;
        reg_rdata[16 +: BUSW] = bus_q;
        reg_rdata[20 +: KW]   = kind_q;
        reg_rdata[24]         = known_q;
        reg_rdata[31]         = vld_q;
      end
      A_IER: reg_rdata[NKIND-1:0] = ier_q;
      default: reg_rdata[NCHAN-1:0] = act_q;
    endcase
  end

  assign chan_active = act_q;
  assign irq         = irq_q;
endmodule

module err_log_reg_chk #(
  parameter int NCHAN = 8,
  parameter int NKIND = 4,
  parameter int BUSW  = 2,
  parameter int KW    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     err_in,
  input logic [$clog2(NCHAN)-1:0] err_chan,
  input logic                     err_chan_known,
  input logic [KW-1:0]            err_kind,
  input logic                     reg_we,
  input logic [1:0]               reg_addr,
  input logic [31:0]              reg_wdata,
  input logic [NCHAN-1:0]         chan_active,
  input logic                     irq,
  input logic                     lock_q,
  input logic                     vld_q,
  input logic [NKIND-1:0]         stat_q,
  input logic [NKIND-1:0]         ier_q,
  input logic [$clog2(NCHAN)-1:0] chan_q,
  input logic [KW-1:0]            kind_q
);
  wire vclr_w = reg_we && reg_addr == 2'd1 && reg_wdata[31];
  wire cfgw   = reg_we && reg_addr == 2'd0;

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in && err_kind < NKIND) |=> stat_q[$past(err_kind)]); // R2
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_in |=> vld_q); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && vld_q && !vclr_w) |=> ($stable(chan_q) && $stable(kind_q))); // R4
  AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && err_in) |=> (kind_q == $past(err_kind) && chan_q == $past(err_chan))); // R6
  AST_CHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in && err_chan_known) |=> !chan_active[$past(err_chan)]); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == '0 && !cfgw) |=> !irq); // R8
endmodule

bind err_log_reg err_log_reg_chk #(.NCHAN(NCHAN), .NKIND(NKIND), .BUSW(BUSW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_chan(err_chan),
  .err_chan_known(err_chan_known), .err_kind(err_kind), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .chan_active(chan_active), .irq(irq),
  .lock_q(lock_q), .vld_q(vld_q), .stat_q(stat_q), .ier_q(ier_q),
  .chan_q(chan_q), .kind_q(kind_q)
);

// File: tb/err_log_reg_tb.sv
`timescale 1ns/1ps
module err_log_reg_tb;
  logic        clk = 0, rst_n = 0;
  logic        err_in = 0, err_chan_known = 0;
  logic [2:0]  err_chan = 0;
  logic [1:0]  err_bus = 0, err_kind = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [7:0]  chan_active;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  err_log_reg u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] esr(logic v, logic kn, logic [1:0] kind,
                                      logic [1:0] bus, logic [2:0] ch, logic [3:0] st);
    return {v, 6'd0, kn, 2'd0, kind, 2'd0, bus, 5'd0, ch, 4'd0, st};
  endfunction

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic cycle(logic we, logic [1:0] a, logic [31:0] wd,
                       logic e, logic [2:0] ch, logic kn, logic [1:0] bus, logic [1:0] kind);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    err_in = e; err_chan = ch; err_chan_known = kn; err_bus = bus; err_kind = kind;
    @(negedge clk);
    reg_we = 0; err_in = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d); cycle(1, a, d, 0, 0, 0, 0, 0); endtask
  task automatic fault(logic [2:0] ch, logic kn, logic [1:0] bus, logic [1:0] kind);
    cycle(0, 0, 0, 1, ch, kn, bus, kind);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); chk("R1 reg", d, 0); end
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(0, 1); rd(0, d); chk("R9 cfg", d, 1);
    wr(2, 32'ha); rd(2, d); chk("R9 ier", d, 32'ha);
    wr(3, 32'h5a); rd(3, d); chk("R9 act", d, 32'h5a);
    wr(0, 0); wr(2, 0);
  endtask

  task automatic t_accum_overwrite();
    logic [31:0] d;
    fault(2, 1, 1, 1);
    rd(1, d); chk("R6 first", d, esr(1, 1, 1, 1, 2, 4'b0010));
    fault(5, 0, 3, 3);
    rd(1, d); chk("R2 accum / R6 overwrite", d, esr(1, 0, 3, 3, 5, 4'b1010));
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(1, 32'h2); rd(1, d); chk("R3 clear one", d[3:0], 4'b1000);
    wr(1, 0); rd(1, d); chk("R3 write zero", d[3:0], 4'b1000);
    cycle(1, 1, 32'h8, 1, 0, 0, 0, 3);
    rd(1, d); chk("R3 error wins", d[3:0], 4'b1000);
    wr(1, 32'h8000_000f); rd(1, d); chk("R5 valid clear", {d[31], d[3:0]}, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(0, 1);
    fault(1, 1, 2, 1);
    fault(6, 1, 1, 2);
    rd(1, d); chk("R4 held first", d, esr(1, 1, 1, 2, 1, 4'b0110));
    wr(1, 32'h8000_0000); rd(1, d); chk("R5 unlock", d[31], 0);
    fault(4, 0, 3, 0);
    rd(1, d); chk("R4 recapture", d, esr(1, 0, 0, 3, 4, 4'b0111));
    cycle(1, 1, 32'h8000_0000, 1, 3, 1, 1, 3);
    rd(1, d); chk("R5 clear race", d, esr(1, 1, 3, 1, 3, 4'b1111));
    wr(0, 0); wr(1, 32'h8000_000f);
  endtask

  task automatic t_chan();
    logic [31:0] d;
    wr(3, 32'hff);
    fault(4, 1, 0, 0); rd(3, d); chk("R7 known", d, 32'hef);
    fault(2, 0, 0, 0); rd(3, d); chk("R7 unknown", d, 32'hef);
    wr(1, 32'h8000_000f);
  endtask

  task automatic t_irq();
    wr(2, 32'h4);
    fault(0, 0, 0, 1);
    @(negedge clk); chk("R8 masked", irq, 0);
    @(negedge clk);
    reg_addr = 0; err_in = 1; err_kind = 2;
    @(negedge clk); err_in = 0;
    chk("R8 lag", irq, 0);
    @(negedge clk); chk("R8 raised", irq, 1);
    reg_we = 1; reg_addr = 1; reg_wdata = 32'h4;
    @(negedge clk); reg_we = 0;
    chk("R8 still", irq, 1);
    @(negedge clk); chk("R8 dropped", irq, 0);
  endtask

  initial begin
    #500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_accum_overwrite();
    t_w1c();
    t_lock();
    t_chan();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule